// File: doc/BRIEF.md
# Half-Second Timebase with Fractional Trim

This block turns a fast system clock into a one-hertz square wave and a 32-bit running count of seconds. A fixed prescaler produces a slow tick. An 8-bit up-counter advances on each tick, and its wraps are counted. A half-second is made of a whole number of wraps plus a short final stretch. That stretch is set up by subtracting a remainder from the counter just after a set number of wraps.

The ratio of clock to tick rarely divides a half-second exactly, so a small fractional accumulator handles the leftover quarter tick. It adds its numerator once per half-second. When it reaches its power-of-two denominator, the final stretch is made one tick longer and the accumulator wraps.

The seconds value counts from midnight at the start of 1904. A host can overwrite any of its bytes through a byte-enabled load port. With the default parameters (clock divided by 1024, 15 full wraps, remainder 66, a quarter-tick fraction), four consecutive half-seconds last exactly 16,000,000 clocks of an 8 MHz input.

Top module: `halfsec_timebase`

## Requirements
- R1: After reset, `sq_wave` is 0 and `seconds` equals the `SEC_INIT` parameter (default 2524608000, i.e. 0x967A7600).
- R2: A normal half-period lasts `PRESC_DIV * (OFLOW_LIM * 2**CNT_W + REM_TICKS)` clocks. The first half-period ends, and `sq_wave` toggles, at that many rising edges after reset is released.
- R3: The fractional accumulator starts at 0 and adds `FRAC_NUM` once per half-period, at the last full wrap. On each half-period where the sum reaches `2**FRAC_W`, the half-period is `PRESC_DIV` clocks longer (one extra tick), and the sum is reduced modulo `2**FRAC_W`. With `FRAC_NUM` = 1 and `FRAC_W` = 2, this happens on every 4th half-period.
- R4: `sq_wave` changes only at the end of a half-period and toggles every time. The first toggle drives it to 1.
- R5: `seconds` advances by exactly one when `sq_wave` goes from 1 to 0. It holds when `sq_wave` rises and at all other times, unless a byte is written.
- R6: A byte enable bit `sec_wr_be[i]` loads `sec_wr_data[8i+7:8i]` into byte i of `seconds` on the next edge. Bytes whose enables are clear keep their value.
- R7: When a byte write and an increment fall on the same edge, the enabled bytes take the written data. The other bytes take the incremented value, including any carry into them.
- R8: `seconds` wraps from 0xFFFFFFFF to 0 on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_wr_be | input | SEC_W/8 | Byte enables for the seconds load, bit i selects byte i |
| sec_wr_data | input | SEC_W | Load data for the seconds counter |
| sq_wave | output | 1 | One-hertz square wave, low after reset |
| seconds | output | SEC_W | Seconds since the 1904 epoch |

## Verification
The bench builds the block with a prescale of 2, a 4-bit wrap counter, 3 full wraps and a remainder of 5. This gives half-periods of 106 clocks, and 108 on every fourth one. With these values, the first eight toggles can be timed edge by edge, so both the trim and the quarter-tick correction are visible within about a thousand cycles. The short period also lets the bench place a host write on the exact edge of an increment, and drive a carry across bytes and through the 32-bit wrap, in a short run.

// File: rtl/hstb_pkg.sv
package hstb_pkg;

    // Seconds from 1904-01-01 to 1984-01-01: 20 spans of 1461 days.
    localparam logic [31:0] EPOCH_1984_SECONDS = 32'd2524608000;

    // What a prescaled tick does to the wrap counter.
    typedef enum logic [1:0] {
        OV_IDLE  = 2'd0,  // no tick this cycle
        OV_STEP  = 2'd1,  // tick, counter advances or wraps plainly
        OV_TRIM  = 2'd2,  // last full wrap: subtract remainder
        OV_HALF  = 2'd3   // final wrap: half-second reached
    } ovf_kind_e;

    // Width needed to hold values 0..n (at least 1 bit).
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hstb_prescaler.sv
module hstb_prescaler #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import hstb_pkg::*;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = width_for(DIV - 1);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pc_q;

            assign tick = (pc_q == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    pc_q <= '0;
                end else if (tick) begin
                    pc_q <= '0;
                end else begin
                    pc_q <= pc_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hstb_ovf_core.sv
module hstb_ovf_core #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned OFLOW_LIM = 15,
    parameter int unsigned REM_TICKS = 66,
    parameter int unsigned FRAC_NUM  = 1,
    parameter int unsigned FRAC_W    = 2,
    parameter int unsigned OCW       = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    output logic           half,
    output logic [OCW-1:0] ocnt
);
    import hstb_pkg::*;

    localparam logic [CNT_W-1:0]  REM_V   = CNT_W'(REM_TICKS);
    localparam logic [OCW-1:0]    TRIM_AT = OCW'(OFLOW_LIM);
    localparam logic [OCW-1:0]    HALF_AT = OCW'(OFLOW_LIM + 1);
    localparam logic [FRAC_W:0]   NUM_V   = (FRAC_W + 1)'(FRAC_NUM);

    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [OCW-1:0]    ocnt_q, ocnt_d, ocnt_inc;
    logic [FRAC_W-1:0] frac_q, frac_d;
    logic [FRAC_W:0]   frac_sum;
    logic              wrap, extra;
    ovf_kind_e         kind;

    assign cnt_inc  = cnt_q + 1'b1;
    assign ocnt_inc = ocnt_q + 1'b1;
    assign wrap     = tick && (cnt_q == '1);
    assign frac_sum = {1'b0, frac_q} + NUM_V;
    assign extra    = frac_sum[FRAC_W];

    always_comb begin
        if (!tick) begin
            kind = OV_IDLE;
        end else if (wrap && (ocnt_inc == TRIM_AT)) begin
            kind = OV_TRIM;
        end else if (wrap && (ocnt_inc == HALF_AT)) begin
            kind = OV_HALF;
        end else begin
            kind = OV_STEP;
        end
    end

    always_comb begin
        cnt_d  = cnt_q;
        ocnt_d = ocnt_q;
        frac_d = frac_q;
        unique case (kind)
            OV_IDLE: ;
            OV_STEP: begin
                cnt_d = cnt_inc;
                if (wrap) ocnt_d = ocnt_inc;
            end
            OV_TRIM: begin
                // subtract from the freshly wrapped value, keeping elapsed ticks
                cnt_d  = cnt_inc - REM_V - CNT_W'(extra);
                ocnt_d = ocnt_inc;
                frac_d = frac_sum[FRAC_W-1:0];
            end
            OV_HALF: begin
                cnt_d  = cnt_inc;
                ocnt_d = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ocnt_q <= '0;
            frac_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            ocnt_q <= ocnt_d;
            frac_q <= frac_d;
        end
    end

    assign half = (kind == OV_HALF);
    assign ocnt = ocnt_q;

endmodule

// File: rtl/hstb_sec_reg.sv
module hstb_sec_reg #(
    parameter int unsigned       SEC_W    = 32,
    parameter logic [SEC_W-1:0]  SEC_INIT = 32'd2524608000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               half,
    input  logic [SEC_W/8-1:0] wr_be,
    input  logic [SEC_W-1:0]   wr_data,
    output logic               wave,
    output logic [SEC_W-1:0]   sec
);
    localparam int unsigned NB = SEC_W / 8;

    logic             wave_q;
    logic [SEC_W-1:0] sec_q, sec_inc, sec_d;
    logic             bump;

    // the toggle that drives the wave low closes a full second
    assign bump    = half && wave_q;
    assign sec_inc = sec_q + SEC_W'(bump);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign sec_d[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : sec_inc[8*b +: 8];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
            sec_q  <= SEC_INIT;
        end else begin
            wave_q <= wave_q ^ half;
            sec_q  <= sec_d;
        end
    end

    assign wave = wave_q;
    assign sec  = sec_q;

endmodule

// File: rtl/halfsec_timebase.sv
module halfsec_timebase #(
    parameter int unsigned       PRESC_DIV = 1024,
    parameter int unsigned       CNT_W     = 8,
    parameter int unsigned       OFLOW_LIM = 15,
    parameter int unsigned       REM_TICKS = 66,
    parameter int unsigned       FRAC_NUM  = 1,
    parameter int unsigned       FRAC_W    = 2,
    parameter int unsigned       SEC_W     = 32,
    parameter logic [SEC_W-1:0]  SEC_INIT  = hstb_pkg::EPOCH_1984_SECONDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEC_W/8-1:0] sec_wr_be,
    input  logic [SEC_W-1:0]   sec_wr_data,
    output logic               sq_wave,
    output logic [SEC_W-1:0]   seconds
);
    import hstb_pkg::*;

    localparam int unsigned OCW = width_for(OFLOW_LIM + 1);

    logic           tick;
    logic           half;
    logic [OCW-1:0] ocnt;

    hstb_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    hstb_ovf_core #(
        .CNT_W     (CNT_W),
        .OFLOW_LIM (OFLOW_LIM),
        .REM_TICKS (REM_TICKS),
        .FRAC_NUM  (FRAC_NUM),
        .FRAC_W    (FRAC_W),
        .OCW       (OCW)
    ) u_core (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .half (half),
        .ocnt (ocnt)
    );

    hstb_sec_reg #(.SEC_W(SEC_W), .SEC_INIT(SEC_INIT)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .half    (half),
        .wr_be   (sec_wr_be),
        .wr_data (sec_wr_data),
        .wave    (sq_wave),
        .sec     (seconds)
    );

endmodule

// File: rtl/halfsec_timebase_chk.sv
module halfsec_timebase_chk #(
    parameter int unsigned SEC_W     = 32,
    parameter int unsigned OFLOW_LIM = 15,
    parameter int unsigned OCW       = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               half,
    input logic [OCW-1:0]     ocnt,
    input logic               sq_wave,
    input logic [SEC_W-1:0]   seconds,
    input logic [SEC_W/8-1:0] wr_be,
    input logic [SEC_W-1:0]   wr_data
);
    // R2
    ocnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ocnt <= OCW'(OFLOW_LIM));

    // R2
    half_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        half |-> tick);

    // R4
    wave_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq_wave) |-> $past(half));

    // R5
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_be == '0) |=> ($fell(sq_wave) ? (seconds == $past(seconds) + 1'b1)
                                          : (seconds == $past(seconds))));

    generate
        for (genvar b = 0; b < SEC_W / 8; b++) begin : g_wr
            // R6
            byte_load_chk: assert property (@(posedge clk) disable iff (rst)
                wr_be[b] |=> (seconds[8*b +: 8] == $past(wr_data[8*b +: 8])));
        end
    endgenerate

endmodule

bind halfsec_timebase halfsec_timebase_chk #(
    .SEC_W     (SEC_W),
    .OFLOW_LIM (OFLOW_LIM),
    .OCW       (OCW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .half    (half),
    .ocnt    (ocnt),
    .sq_wave (sq_wave),
    .seconds (seconds),
    .wr_be   (sec_wr_be),
    .wr_data (sec_wr_data)
);

// File: tb/halfsec_timebase_bench.sv
module halfsec_timebase_bench;

    localparam int unsigned PD   = 2;
    localparam int unsigned CW   = 4;
    localparam int unsigned LIM  = 3;
    localparam int unsigned REMT = 5;
    localparam int unsigned FN   = 1;
    localparam int unsigned FW   = 2;
    localparam logic [31:0] INIT = 32'd2524608000;
    localparam int          HALF_N = PD * (LIM * (1 << CW) + REMT);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  be  = '0;
    logic [31:0] wd  = '0;
    logic        wave;
    logic [31:0] secs;

    int ecount = 0;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    halfsec_timebase #(
        .PRESC_DIV (PD),
        .CNT_W     (CW),
        .OFLOW_LIM (LIM),
        .REM_TICKS (REMT),
        .FRAC_NUM  (FN),
        .FRAC_W    (FW),
        .SEC_W     (32),
        .SEC_INIT  (INIT)
    ) u_halfsec_timebase (
        .clk         (clk),
        .rst         (rst),
        .sec_wr_be   (be),
        .sec_wr_data (wd),
        .sq_wave     (wave),
        .seconds     (secs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        be  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic go_to(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    // one-edge host write landing on edge n
    task automatic write_at(input int n, input logic [3:0] e, input logic [31:0] d);
        go_to(n - 1);
        be = e;
        wd = d;
        @(negedge clk);
        be = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 wave", 32'(wave), 32'd0);
        check("R1 seconds", secs, INIT);
    endtask

    task automatic t_periods();
        int acc = 0;
        int exp_edge = 0;
        logic prev;
        do_reset();
        prev = wave;
        for (int k = 1; k <= 8; k++) begin
            int len;
            acc = acc + FN;
            len = HALF_N;
            if (acc >= (1 << FW)) begin
                len = len + PD;
                acc = acc - (1 << FW);
            end
            exp_edge = exp_edge + len;
            while (wave == prev && ecount < exp_edge + 10) @(negedge clk);
            check((len == HALF_N) ? "R2 toggle edge" : "R3 long toggle edge",
                  32'(ecount), 32'(exp_edge));
            check("R4 wave level", 32'(wave), 32'(k % 2));
            check("R5 seconds at toggle", secs, INIT + 32'(k / 2));
            prev = wave;
        end
    endtask

    task automatic t_partial_write();
        do_reset();
        write_at(50, 4'b0110, 32'h1122_3344);
        check("R6 partial write", secs, {INIT[31:24], 8'h22, 8'h33, INIT[7:0]});
        write_at(60, 4'b0000, 32'hFFFF_FFFF);
        check("R6 no enable no change", secs, {INIT[31:24], 8'h22, 8'h33, INIT[7:0]});
    endtask

    task automatic t_collision();
        do_reset();
        write_at(100, 4'b1111, 32'h0000_01FF);
        check("R6 full write", secs, 32'h0000_01FF);
        // increment edges: 212 and 426
        write_at(212, 4'b0001, 32'h0000_005A);
        check("R7 low byte wins, carry kept", secs, 32'h0000_025A);
        write_at(426, 4'b1000, 32'h7700_0000);
        check("R7 high byte wins", secs, 32'h7700_025B);
    endtask

    task automatic t_wrap();
        do_reset();
        write_at(100, 4'b1111, 32'hFFFF_FFFF);
        go_to(211);
        check("R5 hold before fall", secs, 32'hFFFF_FFFF);
        go_to(212);
        check("R8 wrap to zero", secs, 32'h0000_0000);
        check("R4 wave low after second", 32'(wave), 32'd0);
    endtask

    initial begin
        t_reset();
        t_periods();
        t_partial_write();
        t_collision();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule